// File: doc/BRIEF.md
# Fixed-Point Compare to Condition Field

This block compares a register operand with a second operand, which is a register value or an already-extended immediate. The comparison is signed (two's complement) or unsigned. The outcome is written as a 4-bit condition field into one of eight fields of a 32-bit condition register. A length bit picks a 64-bit or a 32-bit comparison. Two straps set how that bit is treated:

- One strap marks the implementation as 64-bit.
- The other strap makes an invalid length bit on a 32-bit implementation raise an illegal-instruction flag instead of being ignored.

The current condition register enters on `cr_i`, together with an operation strobe. One cycle later the block presents the updated register on `cr_o`, a write enable and the illegal flag. Decode and immediate extension happen upstream.

Top module: `cr_compare_unit`

## Requirements
- R1: While `rst_ni` is low, `cr_o` is zero and `we_o` and `illegal_o` are low.
- R2: On a 64-bit implementation (`impl64_i`=1) with `len_i`=1, all 64 bits of both operands are compared.
- R3: On a 64-bit implementation with `len_i`=0, only bits 31:0 of each operand are compared. Bits 63:32 have no effect on the result.
- R4: On a 32-bit implementation (`impl64_i`=0), the comparison always uses bits 31:0 only.
- R5: On a 32-bit implementation with `len_i`=1 and `strict_i`=1, the cycle after the strobe has `illegal_o`=1 and `we_o`=0, and `cr_o` equals the strobed `cr_i` unchanged.
- R6: On a 32-bit implementation with `len_i`=1 and `strict_i`=0, the length bit is ignored. The result is the normal 32-bit compare with `we_o`=1 and `illegal_o`=0.
- R7: With `signed_i`=1 the operands compare as two's complement numbers (bit 63 or bit 31 is the sign). With `signed_i`=0 they compare as unsigned numbers.
- R8: The written field is {lt, gt, eq, so}, with bit 3 the most significant. Exactly one of lt (a<b), gt (a>b) and eq (a==b) is set.
- R9: Bit 0 of the written field equals `so_i` as sampled with the strobe.
- R10: Field index k on `field_i` replaces bits [31-4k : 28-4k] of `cr_i`, so field 0 is the most significant nibble. All other bits of `cr_o` equal `cr_i`.
- R11: Results appear on the clock edge after `valid_i`. In a cycle following no strobe, `we_o` and `illegal_o` are 0 and `cr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand (register or extended immediate) |
| signed_i | input | 1 | 1: signed compare, 0: unsigned |
| len_i | input | 1 | Length bit: 1 requests 64-bit compare |
| field_i | input | 3 | Destination field index |
| impl64_i | input | 1 | Strap: 64-bit implementation |
| strict_i | input | 1 | Strap: invalid length bit is illegal on 32-bit |
| so_i | input | 1 | Summary-overflow bit |
| cr_i | input | 32 | Current condition register |
| cr_o | output | 32 | Updated condition register |
| we_o | output | 1 | Condition register write enable |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
Eight operand values are swept as all 64 ordered pairs:

- zero, one and all-ones;
- the 32-bit sign boundary and the 64-bit sign boundary;
- the largest positive value;
- two values that share low words but differ in their upper words.

Each pair is applied under every combination of sign mode, length bit and both straps, while the destination field rotates through all eight indices. The pairs with equal low words show whether bits 63:32 leak into a narrow compare. The sign-boundary values show signed and unsigned ordering apart. The strap combinations tell the ignored invalid length bit from the illegal case. Idle cycles after strobes confirm the hold behaviour.

// File: rtl/cr_cmp_pkg.sv
package cr_cmp_pkg;
  localparam int unsigned FIELD_W = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cmp_res_t;

  function automatic logic [FIELD_W-1:0] pack_field(cmp_res_t r, logic so);
    return {r.lt, r.gt, r.eq, so};
  endfunction
endpackage

// File: rtl/cr_cmp_core.sv
module cr_cmp_core
  import cr_cmp_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            signed_i,
  input  logic            wide_i,
  output cmp_res_t        res_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic signed [XLEN:0] a_ext, b_ext;

  // one extra bit carries the sign (or zero) so a single signed compare covers both modes
  always_comb begin
    if (wide_i) begin
      a_ext = {signed_i & a_i[XLEN-1], a_i};
      b_ext = {signed_i & b_i[XLEN-1], b_i};
    end else begin
      a_ext = {{(HALF+1){signed_i & a_i[HALF-1]}}, a_i[HALF-1:0]};
      b_ext = {{(HALF+1){signed_i & b_i[HALF-1]}}, b_i[HALF-1:0]};
    end
    res_o.lt = a_ext < b_ext;
    res_o.gt = a_ext > b_ext;
    res_o.eq = a_ext == b_ext;
  end
endmodule

// File: rtl/cr_field_merge.sv
module cr_field_merge
  import cr_cmp_pkg::*;
#(
  parameter int unsigned NFIELD = 8,
  localparam int unsigned CR_W  = NFIELD * FIELD_W,
  localparam int unsigned IDX_W = $clog2(NFIELD)
) (
  input  logic [CR_W-1:0]    cr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [CR_W-1:0]    cr_o
);
  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    localparam int unsigned HI = CR_W - 1 - k * FIELD_W;
    assign cr_o[HI -: FIELD_W] = (idx_i == IDX_W'(k)) ? field_i : cr_i[HI -: FIELD_W];
  end
endmodule

// File: rtl/cr_compare_unit.sv
module cr_compare_unit
  import cr_cmp_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NFIELD = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [XLEN-1:0]             op_a_i,
  input  logic [XLEN-1:0]             op_b_i,
  input  logic                        signed_i,
  input  logic                        len_i,
  input  logic [$clog2(NFIELD)-1:0]   field_i,
  input  logic                        impl64_i,
  input  logic                        strict_i,
  input  logic                        so_i,
  input  logic [NFIELD*FIELD_W-1:0]   cr_i,
  output logic [NFIELD*FIELD_W-1:0]   cr_o,
  output logic                        we_o,
  output logic                        illegal_o
);
  localparam int unsigned CR_W = NFIELD * FIELD_W;

  cmp_res_t         res;
  logic             wide, bad_form;
  logic [CR_W-1:0]  cr_merged;

  assign wide     = impl64_i & len_i;
  assign bad_form = ~impl64_i & len_i & strict_i;

  cr_cmp_core #(.XLEN(XLEN)) u_core (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .signed_i (signed_i),
    .wide_i   (wide),
    .res_o    (res)
  );

  cr_field_merge #(.NFIELD(NFIELD)) u_merge (
    .cr_i    (cr_i),
    .idx_i   (field_i),
    .field_i (pack_field(res, so_i)),
    .cr_o    (cr_merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_o      <= '0;
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      we_o      <= valid_i & ~bad_form;
      illegal_o <= valid_i & bad_form;
      if (valid_i) cr_o <= bad_form ? cr_i : cr_merged;
    end
  end

  // R8
  result_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot({res.lt, res.gt, res.eq}));

  // R5
  we_illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && illegal_o));

  // R5
  illegal_keeps_cr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bad_form |=> illegal_o && cr_o == $past(cr_i));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !we_o && !illegal_o && $stable(cr_o));

  // R6
  lax_form_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !impl64_i && !strict_i |=> we_o);
endmodule

// File: tb/cr_compare_unit_tb.sv
module cr_compare_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic        signed_i = 1'b0, len_i = 1'b0, impl64_i = 1'b0, strict_i = 1'b0, so_i = 1'b0;
  logic [2:0]  field_i = '0;
  logic [31:0] cr_i = '0;
  logic [31:0] cr_o;
  logic        we_o, illegal_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cr_compare_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .op_a_i, .op_b_i, .signed_i, .len_i, .field_i,
    .impl64_i, .strict_i, .so_i, .cr_i, .cr_o, .we_o, .illegal_o
  );

  function automatic logic [3:0] model_field(logic [63:0] a, logic [63:0] b,
                                             logic sgn, logic wide, logic so);
    logic signed [64:0] x, y;
    if (wide) begin
      x = {sgn & a[63], a};
      y = {sgn & b[63], b};
    end else begin
      x = {{33{sgn & a[31]}}, a[31:0]};
      y = {{33{sgn & b[31]}}, b[31:0]};
    end
    return {x < y, x > y, x == y, so};
  endfunction

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] pats [8];

  initial begin
    pats[0] = 64'h0;
    pats[1] = 64'h1;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0000_0000_8000_0000;
    pats[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[5] = 64'h8000_0000_0000_0000;
    pats[6] = 64'hFFFF_FFFF_0000_0005;
    pats[7] = 64'h0000_0001_0000_0005;

    #5;
    // R1
    check("R1", {cr_o, we_o, illegal_o}, 34'h0);
    repeat (2) @(negedge clk_i);
    check("R1", {cr_o, we_o, illegal_o}, 34'h0);
    rst_ni = 1'b1;

    for (int n = 0; n < 1024; n++) begin
      logic [31:0] cr_exp, cr_in;
      logic [3:0]  fld;
      logic        bad, wide;
      int          k;
      string       tag;
      @(negedge clk_i);
      op_a_i   = pats[n % 8];
      op_b_i   = pats[(n / 8) % 8];
      signed_i = n[6];
      len_i    = n[7];
      impl64_i = n[8];
      strict_i = n[9];
      so_i     = n[0] ^ n[4];
      field_i  = 3'((n * 3 + n / 8) % 8);
      cr_in    = 32'h9E37_79B9 * (n + 1);
      cr_i     = cr_in;
      valid_i  = 1'b1;
      wide     = impl64_i & len_i;
      bad      = !impl64_i && len_i && strict_i;
      fld      = model_field(op_a_i, op_b_i, signed_i, wide, so_i);
      k        = int'(field_i);
      cr_exp   = cr_in;
      if (!bad) cr_exp[31-4*k -: 4] = fld;
      if (bad) tag = "R5";
      else if (!impl64_i && len_i) tag = "R6";
      else if (!impl64_i) tag = "R4";
      else if (len_i) tag = "R2";
      else tag = "R3";
      @(negedge clk_i);
      valid_i = 1'b0;
      cr_i    = ~cr_in;
      // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
      check(tag, {cr_o, we_o, illegal_o}, {cr_exp, !bad, bad});
      if (n % 16 == 15) begin
        @(negedge clk_i);
        // R11
        check("R11", {cr_o, we_o, illegal_o}, {cr_exp, 2'b00});
      end
    end

    // R7: signed vs unsigned at 64-bit sign boundary, field 2
    @(negedge clk_i);
    op_a_i = 64'h8000_0000_0000_0000; op_b_i = 64'h1;
    impl64_i = 1; len_i = 1; strict_i = 0; signed_i = 1; so_i = 0;
    field_i = 3'd2; cr_i = 32'h0; valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    check("R7", {cr_o, we_o, illegal_o}, {32'h0080_0000, 2'b10});
    @(negedge clk_i);
    signed_i = 0; valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    check("R7", {cr_o, we_o, illegal_o}, {32'h0040_0000, 2'b10});
    // R9 R10: eq with so into field 7, other bits kept
    @(negedge clk_i);
    op_b_i = op_a_i; so_i = 1; field_i = 3'd7; cr_i = 32'hFFFF_FFF0; valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    check("R10", {cr_o, we_o, illegal_o}, {32'hFFFF_FFF3, 2'b10});

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule